// File: doc/BRIEF.md
# Priority Interrupt Resolver

The resolver watches eight interrupt request lines and drives a single interrupt request towards a processor. Each line is configured to respond either to a high level or to a low-to-high transition. Lines may be blocked one by one, and several lines may be pending at once; the resolver then forwards only the most urgent one. At reset line 0 is the most urgent and line 7 the least. Software can rotate this order by naming the line that should rank lowest.

When the processor acknowledges, the resolver returns the 3-bit number of the winning line and moves that line into service. A line in service holds back every request of equal or lower rank until software ends it. It ends a line either by naming it or by clearing whichever in-service line ranks highest. Up to four lines can be flagged as carrying requests from external slave controllers, and the acknowledge result reports this flag for the winner. All settings are written and read through a small register port whose 3-bit address selects the register.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, int_req and ack_vld are 0. The trigger, mask, cascade and in-service registers read 0, and the lowest-priority register reads 7.
- R2: A line whose trigger bit (address 0) is 0 requests while its input is high. The input is sampled on one clock edge, so int_req follows it one cycle later, and it drops one cycle after the input falls.
- R3: A line whose trigger bit is 1 latches a pending request on a rising edge of its input. The request stays pending after the input falls and is cleared when that line is acknowledged.
- R4: A line whose mask bit (address 1) is 1 takes no part in arbitration. With its request masked, int_req stays 0, and it rises again once the mask bit is cleared.
- R5: With L held in the lowest-priority register (address 2, bits 2:0), line i ranks (i - L - 1) mod 8, and rank 0 is the most urgent. The winner is the unmasked requesting line with the lowest rank.
- R6: An ack sampled while int_req is 1 gives ack_vld = 1 in the next cycle, together with the winner's number on ack_vec and its cascade flag on ack_cas. The same ack sets the winner's in-service bit. An ack sampled while int_req is 0 changes nothing and leaves ack_vld at 0.
- R7: int_req is 1 only when an unmasked request ranks strictly higher than every line in service.
- R8: Writing address 4 with bit 3 set clears the in-service bit of the line given in bits 2:0.
- R9: Writing address 4 with bit 3 clear clears the highest-ranked in-service bit.
- R10: The cascade register (address 3) accepts a write only when at most four bits are set. A write with more bits set leaves the register unchanged.
- R11: Reads return the register chosen by cfg_addr in the same cycle: 0 trigger, 1 mask, 2 lowest-priority line, 3 cascade flags, 5 requests before masking, 6 in-service. Addresses 4 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for reads and writes |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| ack | input | 1 | Interrupt acknowledge from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| ack_vld | output | 1 | Acknowledge result valid, one cycle after an accepted ack |
| ack_vec | output | 3 | Number of the acknowledged line |
| ack_cas | output | 1 | Acknowledged line is flagged as a cascade input |

## Verification
Some rules are checked on every cycle. ack_vld appears only after an accepted ack, and the acknowledged line is then in service. A fully masked set of lines never raises int_req, the cascade register never holds more than four flags, and a specific end-of-interrupt always clears its line. Other behaviour depends on a sequence of events and is shown only by the bench's scenarios. This covers rotation of the order, nesting of a more urgent line over one already in service, the latching of edge requests, non-specific end-of-interrupt choosing the right line, and rejection of an over-full cascade write. The bench compares these against its reference model on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   // Register select values on the configuration port
   typedef enum logic [2:0] {
      REG_TRIG   = 3'd0,
      REG_MASK   = 3'd1,
      REG_LOWEST = 3'd2,
      REG_CASC   = 3'd3,
      REG_EOI    = 3'd4,
      REG_PEND   = 3'd5,
      REG_INSV   = 3'd6,
      REG_SPARE  = 3'd7
   } reg_sel_e;

   localparam int ADDR_W = 3;
endpackage

// File: rtl/irq_prio_pick.sv
// Finds the most urgent set bit of a vector under a rotated order.
// Rank 0 is the line just above 'lowest'.
module irq_prio_pick #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   input  logic [IDX_W-1:0] lowest,
   output logic             found,
   output logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] rank
);
   logic [N-1:0] rot;

   for (genvar k = 0; k < N; k++) begin : g_rot
      localparam logic [IDX_W-1:0] OFS = IDX_W'(k + 1);
      assign rot[k] = vec[lowest + OFS];
   end

   always_comb begin
      found = 1'b0;
      rank  = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (rot[k]) begin
            found = 1'b1;
            rank  = IDX_W'(k);
         end
      end
   end

   assign idx = lowest + rank + IDX_W'(1);
endmodule

// File: rtl/irq_prio_cfg.sv
// Configuration registers and the end-of-interrupt command decoder.
module irq_prio_cfg
   import irq_prio_pkg::*;
#(
   parameter int N        = 8,
   parameter int DATA_W   = 8,
   parameter int MAX_CASC = 4,
   parameter int IDX_W    = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [N-1:0]      trig_q,
   output logic [N-1:0]      mask_q,
   output logic [IDX_W-1:0]  lowest_q,
   output logic [N-1:0]      casc_q,
   output logic              eoi_req,
   output logic              eoi_spec,
   output logic [IDX_W-1:0]  eoi_line
);
   function automatic int count_ones(logic [N-1:0] v);
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(v[i]);
      return c;
   endfunction

   logic casc_ok;
   assign casc_ok = count_ones(wdata[N-1:0]) <= MAX_CASC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q   <= '0;
         mask_q   <= '0;
         lowest_q <= IDX_W'(N - 1);
         casc_q   <= '0;
      end else if (we) begin
         case (addr)
            REG_TRIG:   trig_q   <= wdata[N-1:0];
            REG_MASK:   mask_q   <= wdata[N-1:0];
            REG_LOWEST: lowest_q <= wdata[IDX_W-1:0];
            REG_CASC:   if (casc_ok) casc_q <= wdata[N-1:0];
            default: ;
         endcase
      end
   end

   // The command bit sits just above the line field
   assign eoi_req  = we && (addr == REG_EOI);
   assign eoi_spec = wdata[IDX_W];
   assign eoi_line = wdata[IDX_W-1:0];
endmodule

// File: rtl/irq_prio_core.sv
// Request capture, arbitration against in-service lines, acknowledge.
module irq_prio_core #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     irq_in,
   input  logic [N-1:0]     trig,
   input  logic [N-1:0]     mask,
   input  logic [IDX_W-1:0] lowest,
   input  logic [N-1:0]     casc,
   input  logic             ack,
   input  logic             eoi_req,
   input  logic             eoi_spec,
   input  logic [IDX_W-1:0] eoi_line,
   output logic             int_req,
   output logic             ack_vld,
   output logic [IDX_W-1:0] ack_vec,
   output logic             ack_cas,
   output logic [N-1:0]     raw_req,
   output logic [N-1:0]     isr_q
);
   logic [N-1:0]     irq_q, pend_q, req, ack_hot, eoi_clr;
   logic             r_found, s_found, accept;
   logic [IDX_W-1:0] r_idx, r_rank, s_idx, s_rank;

   assign raw_req = (trig & pend_q) | (~trig & irq_q);
   assign req     = raw_req & ~mask;

   irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_req_pick (
      .vec(req), .lowest(lowest), .found(r_found), .idx(r_idx), .rank(r_rank));

   irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_isr_pick (
      .vec(isr_q), .lowest(lowest), .found(s_found), .idx(s_idx), .rank(s_rank));

   assign int_req = r_found && (!s_found || (r_rank < s_rank));
   assign accept  = ack && int_req;

   always_comb begin
      ack_hot = '0;
      if (accept) ack_hot[r_idx] = 1'b1;
      eoi_clr = '0;
      if (eoi_req) begin
         if (eoi_spec)     eoi_clr[eoi_line] = 1'b1;
         else if (s_found) eoi_clr[s_idx]    = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q   <= '0;
         pend_q  <= '0;
         isr_q   <= '0;
         ack_vld <= 1'b0;
         ack_vec <= '0;
         ack_cas <= 1'b0;
      end else begin
         irq_q   <= irq_in;
         pend_q  <= ((pend_q & ~ack_hot) | (irq_in & ~irq_q)) & trig;
         isr_q   <= (isr_q & ~eoi_clr) | ack_hot;
         ack_vld <= accept;
         if (accept) begin
            ack_vec <= r_idx;
            ack_cas <= casc[r_idx];
         end
      end
   end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_prio_pkg::*;
#(
   parameter  int N        = 8,
   parameter  int DATA_W   = 8,
   parameter  int MAX_CASC = 4,
   localparam int IDX_W    = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      irq_in,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              ack,
   output logic              int_req,
   output logic              ack_vld,
   output logic [IDX_W-1:0]  ack_vec,
   output logic              ack_cas
);
   if (N < 2 || (1 << IDX_W) != N) begin : g_bad_lines
      $error("line count must be a power of two of at least 2");
   end
   if (DATA_W < N || DATA_W <= IDX_W) begin : g_bad_width
      $error("data width too narrow for the line count");
   end
   if (MAX_CASC < 1 || MAX_CASC > N) begin : g_bad_casc
      $error("cascade limit out of range");
   end

   logic [N-1:0]     trig_q, mask_q, casc_q, raw_req, isr_q;
   logic [IDX_W-1:0] lowest_q, eoi_line;
   logic             eoi_req, eoi_spec;

   irq_prio_cfg #(.N(N), .DATA_W(DATA_W), .MAX_CASC(MAX_CASC), .IDX_W(IDX_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .trig_q(trig_q), .mask_q(mask_q), .lowest_q(lowest_q), .casc_q(casc_q),
      .eoi_req(eoi_req), .eoi_spec(eoi_spec), .eoi_line(eoi_line));

   irq_prio_core #(.N(N), .IDX_W(IDX_W)) u_core (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig_q), .mask(mask_q),
      .lowest(lowest_q), .casc(casc_q), .ack(ack), .eoi_req(eoi_req),
      .eoi_spec(eoi_spec), .eoi_line(eoi_line), .int_req(int_req),
      .ack_vld(ack_vld), .ack_vec(ack_vec), .ack_cas(ack_cas),
      .raw_req(raw_req), .isr_q(isr_q));

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         REG_TRIG:   cfg_rdata[N-1:0]     = trig_q;
         REG_MASK:   cfg_rdata[N-1:0]     = mask_q;
         REG_LOWEST: cfg_rdata[IDX_W-1:0] = lowest_q;
         REG_CASC:   cfg_rdata[N-1:0]     = casc_q;
         REG_PEND:   cfg_rdata[N-1:0]     = raw_req;
         REG_INSV:   cfg_rdata[N-1:0]     = isr_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
   parameter int N        = 8,
   parameter int MAX_CASC = 4,
   parameter int IDX_W    = $clog2(N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic             int_req,
   input logic             ack_vld,
   input logic [IDX_W-1:0] ack_vec,
   input logic             cfg_we,
   input logic [2:0]       cfg_addr,
   input logic [IDX_W:0]   eoi_wdata,
   input logic [N-1:0]     mask_q,
   input logic [N-1:0]     casc_q,
   input logic [N-1:0]     isr_q
);
   // R6
   ack_vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(ack && int_req));

   // R6
   ack_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> isr_q[ack_vec]);

   // R4
   full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !int_req);

   // R10
   casc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(casc_q) <= MAX_CASC);

   // R8
   spec_eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 3'd4 && eoi_wdata[IDX_W] && !(ack && int_req))
      |=> !isr_q[$past(eoi_wdata[IDX_W-1:0])]);
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N(N), .MAX_CASC(MAX_CASC), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .int_req(int_req), .ack_vld(ack_vld),
   .ack_vec(ack_vec), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .eoi_wdata(cfg_wdata[IDX_W:0]), .mask_q(mask_q), .casc_q(casc_q), .isr_q(isr_q));

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/100ps
module irq_prio_resolver_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       ack = 1'b0;
   logic       int_req, ack_vld, ack_cas;
   logic [2:0] ack_vec;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_prio_resolver uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ack(ack), .int_req(int_req),
      .ack_vld(ack_vld), .ack_vec(ack_vec), .ack_cas(ack_cas));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   bit [7:0] m_irqq, m_pend, m_isr, m_trig, m_mask, m_casc;
   int       m_low = 7;
   bit       m_vld, m_cas;
   int       m_vec;

   function automatic int best(bit [7:0] v, int low);
      for (int k = 0; k < 8; k++) begin
         int i = (low + 1 + k) % 8;
         if (v[i]) return i;
      end
      return -1;
   endfunction

   function automatic int rank_of(int i, int low);
      return (i - low - 1 + 16) % 8;
   endfunction

   function automatic bit [7:0] m_raw();
      bit [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = m_trig[i] ? m_pend[i] : m_irqq[i];
      return r;
   endfunction

   function automatic bit m_int();
      int b = best(m_raw() & ~m_mask, m_low);
      int s = best(m_isr, m_low);
      return (b >= 0) && (s < 0 || rank_of(b, m_low) < rank_of(s, m_low));
   endfunction

   function automatic bit [7:0] m_read(logic [2:0] a);
      case (a)
         3'd0: return m_trig;
         3'd1: return m_mask;
         3'd2: return 8'(m_low);
         3'd3: return m_casc;
         3'd5: return m_raw();
         3'd6: return m_isr;
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_irqq = 0; m_pend = 0; m_isr = 0; m_trig = 0; m_mask = 0; m_casc = 0;
         m_low = 7; m_vld = 0; m_cas = 0; m_vec = 0;
      end else begin
         bit acc;
         int w, s, ones;
         bit [7:0] nisr, npend;
         acc = ack && m_int();
         w = best(m_raw() & ~m_mask, m_low);
         nisr = m_isr;
         if (cfg_we && cfg_addr == 3'd4) begin
            if (cfg_wdata[3]) nisr[cfg_wdata[2:0]] = 1'b0;
            else begin
               s = best(m_isr, m_low);
               if (s >= 0) nisr[s] = 1'b0;
            end
         end
         if (acc) nisr[w] = 1'b1;
         for (int i = 0; i < 8; i++)
            npend[i] = m_trig[i] && ((m_pend[i] && !(acc && w == i)) || (irq_in[i] && !m_irqq[i]));
         m_vld = acc;
         if (acc) begin
            m_vec = w;
            m_cas = m_casc[w];
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: m_trig = cfg_wdata;
               3'd1: m_mask = cfg_wdata;
               3'd2: m_low = int'(cfg_wdata[2:0]);
               3'd3: begin
                  ones = 0;
                  for (int i = 0; i < 8; i++) ones += int'(cfg_wdata[i]);
                  if (ones <= 4) m_casc = cfg_wdata;
               end
               default: ;
            endcase
         end
         m_isr = nisr;
         m_pend = npend;
         m_irqq = irq_in;
      end
   end

   // Compare against the model on every clock, mid-cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2/R5/R7 int_req vs model", 32'(int_req), 32'(m_int()));
         chk("R6 ack_vld vs model", 32'(ack_vld), 32'(m_vld));
         if (m_vld) begin
            chk("R6 ack_vec vs model", 32'(ack_vec), 32'(m_vec));
            chk("R6 ack_cas vs model", 32'(ack_cas), 32'(m_cas));
         end
         chk("R11 cfg_rdata vs model", 32'(cfg_rdata), 32'(m_read(cfg_addr)));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n = 1);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic rd(string tag, logic [2:0] a, logic [7:0] exp);
      cfg_addr = a;
      #0.5;
      chk(tag, 32'(cfg_rdata), 32'(exp));
   endtask

   task automatic do_ack();
      ack = 1'b1;
      tick();
      ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 int_req after reset", 32'(int_req), 0);
      chk("R1 ack_vld after reset", 32'(ack_vld), 0);
      rd("R1 lowest line reads 7", 3'd2, 8'h07);
      rd("R1 trigger reads 0", 3'd0, 8'h00);
      rd("R1 in-service reads 0", 3'd6, 8'h00);

      // R2 level line 5, ack, specific EOI
      irq_in = 8'h20;
      tick();
      chk("R2 level request raises int_req", 32'(int_req), 1);
      do_ack();
      chk("R6 ack_vld after ack", 32'(ack_vld), 1);
      chk("R6 ack_vec is line 5", 32'(ack_vec), 5);
      chk("R7 own line in service blocks", 32'(int_req), 0);
      rd("R11 in-service readback", 3'd6, 8'h20);
      wr(3'd4, 8'h0D);
      rd("R8 specific EOI clears line 5", 3'd6, 8'h00);
      chk("R2 level still high re-requests", 32'(int_req), 1);
      irq_in = 8'h00;
      tick();
      chk("R2 level low drops int_req", 32'(int_req), 0);

      // R3 edge line 2
      wr(3'd0, 8'h04);
      irq_in = 8'h04;
      tick();
      irq_in = 8'h00;
      tick(2);
      chk("R3 edge request stays pending", 32'(int_req), 1);
      rd("R11 pending readback", 3'd5, 8'h04);
      do_ack();
      chk("R3 ack_vec is line 2", 32'(ack_vec), 2);
      rd("R3 pending cleared by ack", 3'd5, 8'h00);
      wr(3'd4, 8'h00);
      rd("R9 non-specific EOI clears line 2", 3'd6, 8'h00);
      wr(3'd0, 8'h00);

      // R5 fixed order, then rotated
      irq_in = 8'h48;
      tick(2);
      do_ack();
      chk("R5 default order picks line 3", 32'(ack_vec), 3);
      wr(3'd4, 8'h00);
      wr(3'd2, 8'h03);
      tick();
      do_ack();
      chk("R5 lowest=3 picks line 6", 32'(ack_vec), 6);
      wr(3'd4, 8'h00);
      wr(3'd2, 8'h07);
      irq_in = 8'h00;
      tick(2);

      // R7 nesting and R9
      irq_in = 8'h40;
      tick(2);
      do_ack();
      chk("R6 ack_vec is line 6", 32'(ack_vec), 6);
      irq_in = 8'h42;
      tick(2);
      chk("R7 higher line interrupts in-service", 32'(int_req), 1);
      do_ack();
      chk("R7 nested ack is line 1", 32'(ack_vec), 1);
      rd("R7 two lines in service", 3'd6, 8'h42);
      wr(3'd4, 8'h00);
      rd("R9 highest in-service cleared first", 3'd6, 8'h40);
      irq_in = 8'hC0;
      tick(2);
      chk("R7 lower line blocked by line 6", 32'(int_req), 0);
      wr(3'd4, 8'h00);
      chk("R7 request after last EOI", 32'(int_req), 1);
      irq_in = 8'h00;
      tick(2);

      // R4 mask
      irq_in = 8'h40;
      wr(3'd1, 8'h40);
      tick(2);
      chk("R4 masked line silent", 32'(int_req), 0);
      rd("R4 mask readback", 3'd1, 8'h40);
      wr(3'd1, 8'h00);
      chk("R4 unmasked line requests", 32'(int_req), 1);
      irq_in = 8'h00;
      tick(2);

      // R10 cascade limit and cascade flag on ack
      wr(3'd3, 8'h0F);
      rd("R10 four flags accepted", 3'd3, 8'h0F);
      wr(3'd3, 8'h1F);
      rd("R10 five flags rejected", 3'd3, 8'h0F);
      irq_in = 8'h04;
      tick(2);
      do_ack();
      chk("R6 ack_vec line 2 with cascade", 32'(ack_vec), 2);
      chk("R6 ack_cas set for cascade line", 32'(ack_cas), 1);
      wr(3'd4, 8'h00);
      irq_in = 8'h00;
      tick(2);

      // R6 ack with no request is ignored
      chk("R6 no request before spurious ack", 32'(int_req), 0);
      do_ack();
      chk("R6 spurious ack gives no ack_vld", 32'(ack_vld), 0);
      rd("R6 spurious ack leaves in-service", 3'd6, 8'h00);
      rd("R11 address 4 reads 0", 3'd4, 8'h00);
      rd("R11 address 7 reads 0", 3'd7, 8'h00);
      tick(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule